// File: doc/BRIEF.md
# SMBus Slave Register Access Controller

This block is the serial front end of a small register-mapped port expander. It watches an SMBus/I2C bus, answers to a 7-bit slave address, and turns bus transfers into single-cycle write strobes and read requests toward a four-entry register bank. The bank itself sits outside this block. Entry 0 is normally a live input port, and the other three are storage registers.

SCL and SDA are sampled by a much faster system clock. The block detects START, repeated START and STOP conditions. It pulls SDA low through an open-drain enable. Three transfer shapes are supported:
- write byte: address with write, then command, then one or more data bytes;
- read byte: address with write, command, repeated START, address with read, then data;
- receive byte: address with read and then data, with no command.

The first byte after a write address is a command. Its low bits are kept as a persistent register pointer, so a later receive-byte transfer reads whatever register was last selected. Every byte sent in a read burst comes from a fresh read request, so a burst on the input port delivers new pin samples.

Top module: `smb_regport`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal binary 0011 followed by `strap[2:0]`. Bit 0 of the address byte is the direction, with 1 meaning read. On a mismatch the block does not acknowledge, leaves SDA released, and produces no strobe or request until the next START.
- R2: Each matching address byte, each command byte and each written data byte is acknowledged by holding SDA low through the ninth SCL pulse.
- R3: A command byte of any value is acknowledged. Its low two bits become the register pointer, which persists across transfers until the next command byte.
- R4: On every written data byte, `wr_stb` pulses for exactly one cycle at the start of that byte's acknowledge phase. At that pulse, `wr_sel` equals the pointer and `wr_data` equals the byte, received MSB first. Further data bytes in the same transfer write the same register again.
- R5: A read-byte transfer (write address, command, repeated START, read address) returns the selected register's `rd_data` on SDA, MSB first.
- R6: A receive-byte transfer (read address only) returns data from the register selected by the pointer stored in an earlier transfer.
- R7: Each byte of a read burst is preceded by its own single-cycle `rd_req`, so every byte is a fresh sample. A master NACK ends the burst and leaves SDA released.
- R8: A STOP at any point returns the block to idle with SDA released. A partially received data byte is discarded and produces no `wr_stb`.
- R9: Reset releases SDA, clears `wr_stb` and `rd_req`, returns the state machine to idle, and sets the pointer to 0.
- R10: `sda_pull` changes only while the synchronized SCL is low, and `wr_stb` and `rd_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired value) |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap | input | 3 | Low three address bits |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_sel | output | 2 | Register index for the write |
| wr_data | output | 8 | Byte to be written |
| rd_req | output | 1 | One-cycle read request; `rd_data` is captured in the same cycle |
| rd_sel | output | 2 | Register index for the read |
| rd_data | input | 8 | Register bank read data (combinational) |

## Verification
The hardest situation to reach from the ports is a read burst in which the sampled input changes between bytes. The bench must alter the pin value after a byte's eighth bit but before the acknowledge clock that triggers the next request, so that each returned byte shows which sample it came from. The bench's master tasks take the next pin value as an argument and apply it exactly in that window.

A STOP inside a data byte, and a reset in the middle of a transfer, are also provoked by bit-level master tasks. After each of these, a later transfer reads back through the normal bus interface to show that no write happened and that the pointer is in the expected state.

// File: rtl/smbrp_pkg.sv
package smbrp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_SKIP
  } bus_st_t;

  // True when the received address byte selects this slave.
  function automatic logic addr_hit(input logic [7:0] rx, input logic [3:0] hi,
                                    input logic [2:0] lo);
    return rx[7:1] == {hi, lo};
  endfunction

  // States in which the slave holds SDA low for an acknowledge.
  function automatic logic is_ack_state(input bus_st_t s);
    return (s == ST_ADDR_ACK) || (s == ST_CMD_ACK) || (s == ST_WDATA_ACK);
  endfunction

  // States in which bits are shifted in on SCL rising edges.
  function automatic logic is_rx_state(input bus_st_t s);
    return (s == ST_ADDR) || (s == ST_CMD) || (s == ST_WDATA);
  endfunction

endpackage

// File: rtl/smbrp_sync.sv
module smbrp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_p;
  logic [DEPTH-1:0] sda_p;
  logic scl_prev;
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[DEPTH-2:0], scl_i};
      sda_p <= {sda_p[DEPTH-2:0], sda_i};
    end
  end

  assign scl_lvl  = scl_p[STAGES-1];
  assign sda_lvl  = sda_p[STAGES-1];
  assign scl_prev = scl_p[STAGES];
  assign sda_prev = sda_p[STAGES];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/smbrp_fsm.sv
module smbrp_fsm
  import smbrp_pkg::*;
#(
  parameter int         DW      = 8,
  parameter int         PW      = 2,
  parameter logic [3:0] ADDR_HI = 4'b0011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    strap,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [DW-1:0] rd_data,
  output logic          sda_pull,
  output logic          wr_stb,
  output logic [PW-1:0] ptr,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic          miss_evt,
  output logic          hit_evt
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  bus_st_t       st, st_nx;
  logic [CW-1:0] bcnt;
  logic          full;
  logic [DW-1:0] sh;
  logic [DW-1:0] tx;
  logic          mack;
  logic          clr_cnt, rd_load, wr_fire, cmd_take;

  always_comb begin
    st_nx    = st;
    clr_cnt  = 1'b0;
    rd_load  = 1'b0;
    wr_fire  = 1'b0;
    cmd_take = 1'b0;
    hit_evt  = 1'b0;
    miss_evt = 1'b0;
    if (stop_evt) begin
      st_nx = ST_IDLE;
    end else if (start_evt) begin
      st_nx   = ST_ADDR;
      clr_cnt = 1'b1;
    end else if (scl_fall) begin
      case (st)
        ST_ADDR: if (full) begin
          if (addr_hit(sh, ADDR_HI, strap)) begin
            hit_evt = 1'b1;
            rd_load = sh[0];
            st_nx   = ST_ADDR_ACK;
          end else begin
            miss_evt = 1'b1;
            st_nx    = ST_SKIP;
          end
        end
        ST_ADDR_ACK: begin
          st_nx   = sh[0] ? ST_RDATA : ST_CMD;
          clr_cnt = 1'b1;
        end
        ST_CMD: if (full) begin
          cmd_take = 1'b1;
          st_nx    = ST_CMD_ACK;
        end
        ST_CMD_ACK: begin
          st_nx   = ST_WDATA;
          clr_cnt = 1'b1;
        end
        ST_WDATA: if (full) begin
          wr_fire = 1'b1;
          st_nx   = ST_WDATA_ACK;
        end
        ST_WDATA_ACK: begin
          st_nx   = ST_WDATA;
          clr_cnt = 1'b1;
        end
        ST_RDATA: if (bcnt == LAST) st_nx = ST_RDATA_ACK;
        ST_RDATA_ACK: begin
          if (mack) begin
            rd_load = 1'b1;
            clr_cnt = 1'b1;
            st_nx   = ST_RDATA;
          end else begin
            st_nx = ST_SKIP;
          end
        end
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bcnt    <= '0;
      full    <= 1'b0;
      sh      <= '0;
      tx      <= '0;
      mack    <= 1'b0;
      ptr     <= '0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      st <= st_nx;
      if (clr_cnt) begin
        bcnt <= '0;
        full <= 1'b0;
      end else if (scl_rise && is_rx_state(st)) begin
        sh   <= {sh[DW-2:0], sda_lvl};
        bcnt <= bcnt + 1'b1;
        full <= (bcnt == LAST);
      end else if (scl_fall && st == ST_RDATA) begin
        tx   <= {tx[DW-2:0], 1'b0};
        bcnt <= bcnt + 1'b1;
      end
      if (rd_load) tx <= rd_data;
      if (scl_rise && st == ST_RDATA_ACK) mack <= ~sda_lvl;
      if (cmd_take) ptr <= sh[PW-1:0];
      wr_stb <= wr_fire;
      if (wr_fire) wr_data <= sh;
    end
  end

  assign rd_req   = rd_load;
  assign sda_pull = is_ack_state(st) || (st == ST_RDATA && !tx[DW-1]);
endmodule

// File: rtl/smb_regport.sv
module smb_regport #(
  parameter int         DW          = 8,
  parameter int         NREG        = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ADDR_HI     = 4'b0011,
  localparam int        PW          = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull,
  input  logic [2:0]    strap,
  output logic          wr_stb,
  output logic [PW-1:0] wr_sel,
  output logic [DW-1:0] wr_data,
  output logic          rd_req,
  output logic [PW-1:0] rd_sel,
  input  logic [DW-1:0] rd_data
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic miss_evt, hit_evt;
  logic [PW-1:0] ptr;

  smbrp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smbrp_fsm #(.DW(DW), .PW(PW), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst_n(rst_n), .strap(strap), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .rd_data(rd_data), .sda_pull(sda_pull),
    .wr_stb(wr_stb), .ptr(ptr), .wr_data(wr_data), .rd_req(rd_req),
    .miss_evt(miss_evt), .hit_evt(hit_evt)
  );

  assign wr_sel = ptr;
  assign rd_sel = ptr;
endmodule

// File: rtl/smbrp_chk.sv
module smbrp_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic sda_pull,
  input logic wr_stb,
  input logic rd_req,
  input logic stop_evt,
  input logic miss_evt
);
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_lvl);
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_req));
  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);
  assert_miss_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> !sda_pull);
endmodule

bind smb_regport smbrp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_pull(sda_pull),
  .wr_stb(wr_stb), .rd_req(rd_req), .stop_evt(stop_evt), .miss_evt(miss_evt)
);

// File: tb/sim_smb_regport.sv
`timescale 1ns/1ps
module sim_smb_regport;
  localparam int H = 16;
  localparam int Q = 8;
  localparam int NV = 7;
  // {command, data}
  localparam logic [15:0] VEC [NV] = '{16'h01A5, 16'h023C, 16'h030F, 16'hF581,
                                       16'hFEC3, 16'h075A, 16'h0077};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic [7:0] pins = 8'h00;
  logic sda_pull, wr_stb, rd_req;
  logic [1:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data;
  logic sda_i;
  logic [7:0] bank [4];
  int wr_cnt = 0, rd_cnt = 0, overlap = 0;
  logic [1:0] last_sel;
  logic [7:0] last_data;
  int tests = 0, fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_i = sda_m & ~sda_pull;
  assign rd_data = (rd_sel == 2'd0) ? pins : bank[rd_sel];

  smb_regport u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_pull(sda_pull),
    .strap(strap), .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) bank[i] <= 8'h00;
    end else begin
      if (wr_stb) begin
        wr_cnt <= wr_cnt + 1;
        last_sel <= wr_sel;
        last_data <= wr_data;
        if (wr_sel != 2'd0) bank[wr_sel] <= wr_data;
      end
      if (rd_req) rd_cnt <= rd_cnt + 1;
      if (wr_stb && rd_req) overlap <= overlap + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start;
    sda_m = 1'b1; scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0;
  endtask

  task automatic b_rstart;
    wt(Q); sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0;
  endtask

  task automatic b_stop;
    wt(Q); sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic wbit(input logic b);
    wt(Q); sda_m = b; wt(Q);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0;
  endtask

  task automatic rbit(output logic b);
    wt(Q); sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    b = sda_i; wt(Q);
    scl_m = 1'b0;
  endtask

  task automatic send(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic recv(input logic mack, input logic [7:0] nxt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      v[i] = b;
    end
    pins = nxt;
    wbit(~mack);
  endtask

  function automatic logic [7:0] aw(input logic [2:0] s);
    return {4'b0011, s, 1'b0};
  endfunction
  function automatic logic [7:0] ar(input logic [2:0] s);
    return {4'b0011, s, 1'b1};
  endfunction

  task automatic t_write(input logic [7:0] cmd, input logic [7:0] d, output logic [2:0] acks);
    logic a0, a1, a2;
    b_start; send(aw(strap), a0); send(cmd, a1); send(d, a2); b_stop;
    acks = {a0, a1, a2};
  endtask

  task automatic t_ptr(input logic [7:0] cmd, output logic [1:0] acks);
    logic a0, a1;
    b_start; send(aw(strap), a0); send(cmd, a1); b_stop;
    acks = {a0, a1};
  endtask

  task automatic t_read(input logic [7:0] cmd, output logic [7:0] v, output logic [2:0] acks);
    logic a0, a1, a2;
    b_start; send(aw(strap), a0); send(cmd, a1);
    b_rstart; send(ar(strap), a2); recv(1'b0, pins, v); b_stop;
    acks = {a0, a1, a2};
  endtask

  task automatic t_recv(output logic [7:0] v, output logic ack);
    b_start; send(ar(strap), ack); recv(1'b0, pins, v); b_stop;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary;
    end
  end

  initial begin
    logic [2:0] a3;
    logic [1:0] a2;
    logic [7:0] v;
    logic a;
    int w0, r0;
    wt(4);
    chk("R9 reset sda_pull", sda_pull, 0);
    chk("R9 reset wr_stb", wr_stb, 0);
    chk("R9 reset rd_req", rd_req, 0);
    rst_n = 1'b1; wt(4);

    // Table walk: write each entry, then read it back with read-byte
    for (int k = 0; k < NV; k++) begin
      logic [7:0] c, d, exp;
      c = VEC[k][15:8]; d = VEC[k][7:0];
      pins = 8'h4E;
      w0 = wr_cnt;
      t_write(c, d, a3);
      chk("R2 write acks", a3, 3'b111);
      chk("R4 one strobe", wr_cnt - w0, 1);
      chk("R3 wr_sel from cmd low bits", last_sel, c[1:0]);
      chk("R4 wr_data", last_data, d);
      exp = (c[1:0] == 2'd0) ? pins : d;
      t_read(c, v, a3);
      chk("R2 read-byte acks", a3, 3'b111);
      chk("R5 read-byte data", v, exp);
    end

    // R1: wrong address ignored
    w0 = wr_cnt; r0 = rd_cnt;
    b_start; send({4'b0011, 3'b100, 1'b0}, a);
    chk("R1 mismatch nack", a, 0);
    send(8'h02, a); chk("R1 ignored cmd nack", a, 0);
    send(8'hEE, a); chk("R1 ignored data nack", a, 0);
    b_stop;
    chk("R1 no write on mismatch", wr_cnt - w0, 0);
    chk("R1 no read on mismatch", rd_cnt - r0, 0);
    t_read(8'h02, v, a3);
    chk("R1 bank2 untouched", v, 8'hC3);
    // R1: address follows strap
    strap = 3'b010;
    t_write(8'h03, 8'h66, a3);
    chk("R1 new strap acked", a3, 3'b111);
    chk("R1 new strap write", bank[3], 8'h66);

    // R4: two data bytes in one transfer
    w0 = wr_cnt;
    b_start; send(aw(strap), a); send(8'h01, a); send(8'h10, a); send(8'h20, a); b_stop;
    chk("R4 two strobes", wr_cnt - w0, 2);
    chk("R4 second byte same reg", last_sel, 2'd1);
    t_read(8'h01, v, a3);
    chk("R4 reg1 final", v, 8'h20);

    // R6: receive byte uses stored pointer
    t_ptr(8'h03, a2);
    chk("R3 pointer-only acks", a2, 2'b11);
    t_recv(v, a);
    chk("R6 recv ack", a, 1);
    chk("R6 recv data", v, 8'h66);

    // R7: input burst, fresh sample per byte
    t_ptr(8'h00, a2);
    r0 = rd_cnt;
    pins = 8'h11;
    b_start; send(ar(strap), a);
    recv(1'b1, 8'h22, v); chk("R7 burst byte0", v, 8'h11);
    recv(1'b1, 8'h33, v); chk("R7 burst byte1", v, 8'h22);
    recv(1'b0, 8'h44, v); chk("R7 burst byte2", v, 8'h33);
    wt(Q);
    chk("R7 released after nack", sda_pull, 0);
    b_stop;
    chk("R7 three requests", rd_cnt - r0, 3);

    // R8: STOP inside a data byte
    w0 = wr_cnt;
    b_start; send(aw(strap), a); send(8'h02, a);
    wbit(1); wbit(0); wbit(1); wbit(1);
    b_stop;
    chk("R8 partial byte no strobe", wr_cnt - w0, 0);
    chk("R8 sda released", sda_pull, 0);
    t_recv(v, a);
    chk("R8 reg2 kept", v, 8'hC3);

    // R9: reset mid-transfer, pointer back to 0
    b_start; send(aw(strap), a); send(8'h03, a); wbit(1); wbit(1);
    rst_n = 1'b0; wt(4);
    chk("R9 midreset sda_pull", sda_pull, 0);
    sda_m = 1'b1; wt(2); scl_m = 1'b1; wt(4);
    rst_n = 1'b1; wt(H);
    pins = 8'h96;
    t_recv(v, a);
    chk("R9 pointer reset to 0", v, 8'h96);

    chk("R10 no strobe/request overlap", overlap, 0);
    done = 1'b1;
    summary;
  end
endmodule